// File: doc/BRIEF.md
# Power Management Event Status Register

This block holds the sixteen-bit event status word of a chipset power-management unit. Hardware events latch into sticky flags: a resume from the sleep state, the power-button override, a real-time-clock alarm, the sleep button, the power button, a global firmware release, bus-master activity and a carry of the power-management timer. Software reads the word and clears any flag by writing a 1 to its position. Bits with no defined event always read 0.

The block also watches the free-running timer for a change in its top bit. The bit it watches depends on whether the timer runs 24 or 32 bits wide. When a wake flag is raised, it emits a one-cycle request that returns the system to the working state. The event inputs arrive already debounced and one cycle long.

Two resets are used. The system reset clears only the flags that do not need to survive a power cycle. The soft-off reset clears every flag. This lets the button and alarm flags report the cause of a wake from soft off.

Top module: `pm_evt_status`

## Requirements
- R1: Bits 14, 13, 12, 7, 6, 3, 2 and 1 of `status` read 0 at all times, and every flag reads 0 after a soft-off reset.
- R2: When `wr_en` is high, each 1 in `wr_data` clears the matching flag at the next clock edge. A 0 leaves the flag unchanged.
- R3: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R4: Bit 15 (wake) is set only when `in_sleep` is high and at least one `resume_evt` bit is high with its `resume_en` bit also high. `wake_req` is high for exactly the one cycle in which bit 15 goes from 0 to 1.
- R5: Bit 0 (timer carry) is set one edge after bit 23 of `tmr_val` changes while `tmr_wide`=0, or after bit 31 changes while `tmr_wide`=1. A change in the unselected bit has no effect. The first sample after any reset never sets the bit.
- R6: Bit 10 (alarm) follows `rtc_alarm` when `ext_rtc_sel`=0. When `ext_rtc_sel`=1 it follows `ext_irq`, but only while `pin_irq_func`=1.
- R7: Bit 11 (override) is set by `pwrbtn_ovr_evt`. In the same edge bit 8 (power button) is cleared, even if a power-button event arrives in that cycle.
- R8: `rst` clears bits 15, 5, 4 and 0 and leaves bits 11, 10, 9 and 8 as they were. `soft_rst` clears all flags.
- R9: Bit 5 (global) is set by `bios_rls_set`.
- R10: Bit 4 (bus master) is set only while `in_c3`=1, by `bm_frame` gated by `bm_sel[0]`, by `bm_req` gated by `bm_sel[1]`, or by `bm_int` gated by `bm_sel[2]`.
- R11: Bit 9 (sleep button) is set by `slpbtn_evt`, and bit 8 (power button) by `pwrbtn_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| soft_rst | input | 1 | Soft-off reset, synchronous, active high |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write-1-to-clear mask |
| in_sleep | input | 1 | System is in the sleep state |
| resume_evt | input | NUM_RESUME | Resume event pulses |
| resume_en | input | NUM_RESUME | Per-source resume enables |
| pwrbtn_evt | input | 1 | Debounced power-button press |
| pwrbtn_ovr_evt | input | 1 | Power button held past the override time |
| slpbtn_evt | input | 1 | Debounced sleep-button press |
| rtc_alarm | input | 1 | Internal clock alarm |
| ext_irq | input | 1 | External clock interrupt on the shared pin |
| ext_rtc_sel | input | 1 | External real-time clock is in use |
| pin_irq_func | input | 1 | Shared pin is configured as the interrupt input |
| bios_rls_set | input | 1 | Firmware release bit was set |
| in_c3 | input | 1 | Processor is in the C3 state |
| bm_frame | input | 1 | Bus frame activity |
| bm_req | input | 1 | External bus-master request |
| bm_int | input | 1 | Internal master requesting the bus |
| bm_sel | input | 3 | Bus-master source enables |
| tmr_val | input | TMR_W | Current power-management timer value |
| tmr_wide | input | 1 | 1 selects a 32-bit timer, 0 a 24-bit timer |
| status | output | 16 | Event status word |
| wake_req | output | 1 | One-cycle request to return to the working state |

## Verification
A hardware set and a software write-1-to-clear can land on the same flag in the same edge. A reset and a set can also coincide. The override event and a power-button press can arrive together. The bench raises events at a low random rate and writes random clear masks, so these collisions happen many times. It also runs directed cases that hold a flag at 1 while its event and a clear arrive together, and that fire the override and a button press in one cycle. A model in the bench applies the stated priorities (reset, then override clear, then set, then clear) and the result is compared field by field after every edge.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int STW     = 16;
    localparam int BM_NSRC = 3;

    localparam int B_WAKE = 15;
    localparam int B_OVR  = 11;
    localparam int B_RTC  = 10;
    localparam int B_SLP  = 9;
    localparam int B_PWR  = 8;
    localparam int B_GBL  = 5;
    localparam int B_BM   = 4;
    localparam int B_TMR  = 0;

    localparam logic [STW-1:0] DEF_MASK    = 16'h8F31;
    localparam logic [STW-1:0] RETAIN_MASK = 16'h0F00;

    typedef enum int {BM_FRAME = 0, BM_EXTREQ = 1, BM_INTREQ = 2} bm_src_e;

    typedef struct packed {
        logic wake;
        logic ovr;
        logic rtc;
        logic slp;
        logic pwr;
        logic gbl;
        logic bm;
        logic tmr;
    } evt_t;

    function automatic logic [STW-1:0] evt_to_vec(input evt_t e);
        logic [STW-1:0] v;
        v         = '0;
        v[B_WAKE] = e.wake;
        v[B_OVR]  = e.ovr;
        v[B_RTC]  = e.rtc;
        v[B_SLP]  = e.slp;
        v[B_PWR]  = e.pwr;
        v[B_GBL]  = e.gbl;
        v[B_BM]   = e.bm;
        v[B_TMR]  = e.tmr;
        return v;
    endfunction
endpackage

// File: rtl/pm_tmr_carry.sv
module pm_tmr_carry #(
    parameter int TMR_W      = 32,
    parameter int NARROW_TOP = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             wide,
    output logic             carry
);
    localparam int WIDE_TOP = TMR_W - 1;

    logic prev_n, prev_w, primed;
    logic unused_tmr;

    assign unused_tmr = ^tmr_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b0;
            prev_w <= 1'b0;
            primed <= 1'b0;
        end else begin
            prev_n <= tmr_val[NARROW_TOP];
            prev_w <= tmr_val[WIDE_TOP];
            primed <= 1'b1;
        end
    end

    always_comb begin
        if (!primed)
            carry = 1'b0;
        else if (wide)
            carry = tmr_val[WIDE_TOP] ^ prev_w;
        else
            carry = tmr_val[NARROW_TOP] ^ prev_n;
    end
endmodule

// File: rtl/pm_evt_src.sv
module pm_evt_src import pm_evt_pkg::*; #(
    parameter int NUM_RESUME = 8
) (
    input  logic                  in_sleep,
    input  logic [NUM_RESUME-1:0] resume_evt,
    input  logic [NUM_RESUME-1:0] resume_en,
    input  logic                  pwrbtn_evt,
    input  logic                  pwrbtn_ovr_evt,
    input  logic                  slpbtn_evt,
    input  logic                  rtc_alarm,
    input  logic                  ext_irq,
    input  logic                  ext_rtc_sel,
    input  logic                  pin_irq_func,
    input  logic                  bios_rls_set,
    input  logic                  in_c3,
    input  logic                  bm_frame,
    input  logic                  bm_req,
    input  logic                  bm_int,
    input  logic [BM_NSRC-1:0]    bm_sel,
    input  logic                  tmr_carry,
    output evt_t                  evt
);
    logic [BM_NSRC-1:0] bm_raw;
    logic               alarm_src;

    assign bm_raw[BM_FRAME]  = bm_frame;
    assign bm_raw[BM_EXTREQ] = bm_req;
    assign bm_raw[BM_INTREQ] = bm_int;

    always_comb begin
        alarm_src = ext_rtc_sel ? (ext_irq & pin_irq_func) : rtc_alarm;
        evt.wake  = in_sleep & (|(resume_evt & resume_en));
        evt.ovr   = pwrbtn_ovr_evt;
        evt.rtc   = alarm_src;
        evt.slp   = slpbtn_evt;
        evt.pwr   = pwrbtn_evt;
        evt.gbl   = bios_rls_set;
        evt.bm    = in_c3 & (|(bm_raw & bm_sel));
        evt.tmr   = tmr_carry;
    end
endmodule

// File: rtl/pm_status_bits.sv
module pm_status_bits import pm_evt_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           soft_rst,
    input  logic [STW-1:0] set_vec,
    input  logic [STW-1:0] clr_vec,
    input  logic [STW-1:0] force_clr,
    output logic [STW-1:0] bits_q
);
    logic unused_rsv;
    assign unused_rsv = ^((set_vec | clr_vec | force_clr) & ~DEF_MASK);

    for (genvar i = 0; i < STW; i++) begin : g_bit
        if (DEF_MASK[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (soft_rst || (rst && !RETAIN_MASK[i]))
                    bit_q <= 1'b0;
                else if (force_clr[i])
                    bit_q <= 1'b0;
                else if (set_vec[i])
                    bit_q <= 1'b1;
                else if (clr_vec[i])
                    bit_q <= 1'b0;
            end
            assign bits_q[i] = bit_q;
        end else begin : g_rsv
            assign bits_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status import pm_evt_pkg::*; #(
    parameter int NUM_RESUME = 8,
    parameter int TMR_W      = 32,
    parameter int NARROW_TOP = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic [STW-1:0]        wr_data,
    input  logic                  in_sleep,
    input  logic [NUM_RESUME-1:0] resume_evt,
    input  logic [NUM_RESUME-1:0] resume_en,
    input  logic                  pwrbtn_evt,
    input  logic                  pwrbtn_ovr_evt,
    input  logic                  slpbtn_evt,
    input  logic                  rtc_alarm,
    input  logic                  ext_irq,
    input  logic                  ext_rtc_sel,
    input  logic                  pin_irq_func,
    input  logic                  bios_rls_set,
    input  logic                  in_c3,
    input  logic                  bm_frame,
    input  logic                  bm_req,
    input  logic                  bm_int,
    input  logic [BM_NSRC-1:0]    bm_sel,
    input  logic [TMR_W-1:0]      tmr_val,
    input  logic                  tmr_wide,
    output logic [STW-1:0]        status,
    output logic                  wake_req
);
    logic           carry;
    evt_t           evt;
    logic [STW-1:0] set_vec, clr_vec, force_clr;
    logic           wake_req_q;

    pm_tmr_carry #(.TMR_W(TMR_W), .NARROW_TOP(NARROW_TOP)) u_carry (
        .clk     (clk),
        .rst     (rst | soft_rst),
        .tmr_val (tmr_val),
        .wide    (tmr_wide),
        .carry   (carry)
    );

    pm_evt_src #(.NUM_RESUME(NUM_RESUME)) u_src (
        .in_sleep       (in_sleep),
        .resume_evt     (resume_evt),
        .resume_en      (resume_en),
        .pwrbtn_evt     (pwrbtn_evt),
        .pwrbtn_ovr_evt (pwrbtn_ovr_evt),
        .slpbtn_evt     (slpbtn_evt),
        .rtc_alarm      (rtc_alarm),
        .ext_irq        (ext_irq),
        .ext_rtc_sel    (ext_rtc_sel),
        .pin_irq_func   (pin_irq_func),
        .bios_rls_set   (bios_rls_set),
        .in_c3          (in_c3),
        .bm_frame       (bm_frame),
        .bm_req         (bm_req),
        .bm_int         (bm_int),
        .bm_sel         (bm_sel),
        .tmr_carry      (carry),
        .evt            (evt)
    );

    always_comb begin
        set_vec        = evt_to_vec(evt);
        clr_vec        = wr_en ? wr_data : '0;
        force_clr      = '0;
        force_clr[B_PWR] = evt.ovr;
    end

    pm_status_bits u_bits (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .force_clr (force_clr),
        .bits_q    (status)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            wake_req_q <= 1'b0;
        else
            wake_req_q <= evt.wake & ~status[B_WAKE];
    end

    assign wake_req = wake_req_q;
endmodule

// File: rtl/pm_evt_status_chk.sv
module pm_evt_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        soft_rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        slpbtn_evt,
    input logic        in_sleep,
    input logic        in_c3,
    input logic [15:0] status,
    input logic        wake_req
);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (soft_rst)
        (status & 16'h70CE) == 16'h0000);

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (wr_en && wr_data[9] && !slpbtn_evt) |=> !status[9]);

    // R4
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        wake_req |-> (status[15] && !$past(status[15])));

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        wake_req |=> !wake_req);

    // R4
    wake_sleep_only_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(status[15]) |-> $past(in_sleep));

    // R7
    ovr_clears_pwr_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(status[11]) |-> !status[8]);

    // R8
    soft_clear_chk: assert property (@(posedge clk)
        soft_rst |=> (status == 16'h0000));

    // R10
    bm_c3_only_chk: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(status[4]) |-> $past(in_c3));
endmodule

bind pm_evt_status pm_evt_status_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .slpbtn_evt (slpbtn_evt),
    .in_sleep   (in_sleep),
    .in_c3      (in_c3),
    .status     (status),
    .wake_req   (wake_req)
);

// File: tb/pm_evt_status_tb_top.sv
`timescale 1ns/1ps
module pm_evt_status_tb_top;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst, soft_rst, wr_en;
    logic [15:0] wr_data;
    logic        in_sleep;
    logic [NR-1:0] resume_evt, resume_en;
    logic        pwrbtn_evt, pwrbtn_ovr_evt, slpbtn_evt, rtc_alarm, ext_irq;
    logic        ext_rtc_sel, pin_irq_func, bios_rls_set, in_c3;
    logic        bm_frame, bm_req, bm_int;
    logic [2:0]  bm_sel;
    logic [31:0] tmr_val;
    logic        tmr_wide;
    logic [15:0] status;
    logic        wake_req;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_st;
    logic        m_wreq;
    logic        m_p23, m_p31, m_primed;

    always #10 clk = ~clk;

    pm_evt_status #(.NUM_RESUME(NR)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
        .in_sleep(in_sleep), .resume_evt(resume_evt), .resume_en(resume_en),
        .pwrbtn_evt(pwrbtn_evt), .pwrbtn_ovr_evt(pwrbtn_ovr_evt), .slpbtn_evt(slpbtn_evt),
        .rtc_alarm(rtc_alarm), .ext_irq(ext_irq), .ext_rtc_sel(ext_rtc_sel),
        .pin_irq_func(pin_irq_func), .bios_rls_set(bios_rls_set), .in_c3(in_c3),
        .bm_frame(bm_frame), .bm_req(bm_req), .bm_int(bm_int), .bm_sel(bm_sel),
        .tmr_val(tmr_val), .tmr_wide(tmr_wide), .status(status), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; soft_rst = 0; wr_en = 0; wr_data = '0;
        in_sleep = 0; resume_evt = '0; resume_en = '0;
        pwrbtn_evt = 0; pwrbtn_ovr_evt = 0; slpbtn_evt = 0; rtc_alarm = 0; ext_irq = 0;
        ext_rtc_sel = 0; pin_irq_func = 0; bios_rls_set = 0; in_c3 = 0;
        bm_frame = 0; bm_req = 0; bm_int = 0; bm_sel = '0; tmr_wide = 0;
    endtask

    // Model of one edge, from the requirements; inputs are set before the call.
    task automatic step();
        logic [15:0] setv, n;
        logic        carry, alarm;
        alarm = ext_rtc_sel ? (ext_irq & pin_irq_func) : rtc_alarm;
        carry = m_primed && (tmr_wide ? (tmr_val[31] != m_p31) : (tmr_val[23] != m_p23));
        setv = '0;
        setv[15] = in_sleep && ((resume_evt & resume_en) != '0);
        setv[11] = pwrbtn_ovr_evt;
        setv[10] = alarm;
        setv[9]  = slpbtn_evt;
        setv[8]  = pwrbtn_evt;
        setv[5]  = bios_rls_set;
        setv[4]  = in_c3 && ((bm_frame && bm_sel[0]) || (bm_req && bm_sel[1]) || (bm_int && bm_sel[2]));
        setv[0]  = carry;
        n = m_st;
        if (wr_en) n = n & ~wr_data;
        n = n | setv;
        if (pwrbtn_ovr_evt) n[8] = 1'b0;
        n = n & 16'h8F31;
        m_wreq = setv[15] && !m_st[15];
        if (soft_rst) begin
            n = '0; m_wreq = 0;
        end else if (rst) begin
            n = n & 16'h0F00; m_wreq = 0;
        end
        if (soft_rst || rst) m_primed = 0;
        else begin
            m_primed = 1; m_p23 = tmr_val[23]; m_p31 = tmr_val[31];
        end
        m_st = n;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "reserved bits", {16'h0, status & 16'h70CE}, 32'h0);
        chk("R4", "wake bit", {31'h0, status[15]}, {31'h0, m_st[15]});
        chk("R4", "wake_req", {31'h0, wake_req}, {31'h0, m_wreq});
        chk("R7", "override bit", {31'h0, status[11]}, {31'h0, m_st[11]});
        chk("R6", "alarm bit", {31'h0, status[10]}, {31'h0, m_st[10]});
        chk("R11", "sleep button bit", {31'h0, status[9]}, {31'h0, m_st[9]});
        chk("R11", "power button bit", {31'h0, status[8]}, {31'h0, m_st[8]});
        chk("R9", "global bit", {31'h0, status[5]}, {31'h0, m_st[5]});
        chk("R10", "bus master bit", {31'h0, status[4]}, {31'h0, m_st[4]});
        chk("R5", "timer carry bit", {31'h0, status[0]}, {31'h0, m_st[0]});
    endtask

    task automatic randomize_inputs();
        idle();
        rst            = ($urandom % 60) == 0;
        soft_rst       = ($urandom % 120) == 0;
        wr_en          = ($urandom % 4) == 0;
        wr_data        = 16'($urandom);
        in_sleep       = ($urandom % 2) == 0;
        resume_evt     = NR'($urandom) & NR'($urandom) & NR'($urandom);
        resume_en      = NR'($urandom);
        pwrbtn_evt     = ($urandom % 12) == 0;
        pwrbtn_ovr_evt = ($urandom % 20) == 0;
        slpbtn_evt     = ($urandom % 12) == 0;
        rtc_alarm      = ($urandom % 8) == 0;
        ext_irq        = ($urandom % 8) == 0;
        ext_rtc_sel    = ($urandom % 2) == 0;
        pin_irq_func   = ($urandom % 2) == 0;
        bios_rls_set   = ($urandom % 12) == 0;
        in_c3          = ($urandom % 2) == 0;
        bm_frame       = ($urandom % 6) == 0;
        bm_req         = ($urandom % 6) == 0;
        bm_int         = ($urandom % 6) == 0;
        bm_sel         = 3'($urandom);
        tmr_wide       = ($urandom % 2) == 0;
        if (($urandom % 5) == 0) tmr_val = $urandom;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        tmr_val = '0;
        m_st = '0; m_wreq = 0; m_p23 = 0; m_p31 = 0; m_primed = 0;
        @(negedge clk);
        soft_rst = 1; step(); soft_rst = 0;
        chk("R8", "status after soft reset", {16'h0, status}, 32'h0);

        // R2: write 0 keeps, write 1 clears
        slpbtn_evt = 1; step(); slpbtn_evt = 0;
        wr_en = 1; wr_data = 16'hFDFF; step();
        chk("R2", "write 0 keeps bit 9", {31'h0, status[9]}, 32'h1);
        wr_data = 16'h0200; step(); wr_en = 0;
        chk("R2", "write 1 clears bit 9", {31'h0, status[9]}, 32'h0);

        // R3: set and clear together
        slpbtn_evt = 1; step();
        wr_en = 1; wr_data = 16'h0200; step(); wr_en = 0; slpbtn_evt = 0;
        chk("R3", "set beats clear", {31'h0, status[9]}, 32'h1);

        // R7: override with a power-button press in the same cycle
        pwrbtn_evt = 1; pwrbtn_ovr_evt = 1; step(); pwrbtn_evt = 0; pwrbtn_ovr_evt = 0;
        chk("R7", "override set, power cleared", {30'h0, status[11], status[8]}, 32'h2);

        // R5: unselected top bit ignored
        tmr_wide = 0; tmr_val = 32'h8000_0000; step();
        chk("R5", "bit 31 ignored in narrow mode", {31'h0, status[0]}, 32'h0);
        tmr_val = 32'h8080_0000; step();
        chk("R5", "bit 23 change sets carry", {31'h0, status[0]}, 32'h1);

        // R8: system reset keeps retained flags
        pwrbtn_evt = 1; bios_rls_set = 1; step(); pwrbtn_evt = 0; bios_rls_set = 0;
        rst = 1; step(); rst = 0;
        chk("R8", "rst keeps bits 11..8", {16'h0, status}, 32'h0B00);
        soft_rst = 1; step(); soft_rst = 0;
        chk("R8", "soft reset clears all", {16'h0, status}, 32'h0);

        // R4: wake only in sleep
        resume_evt = 8'h01; resume_en = 8'h01; in_sleep = 0; step();
        chk("R4", "no wake outside sleep", {31'h0, status[15]}, 32'h0);
        in_sleep = 1; step();
        chk("R4", "wake pulse", {30'h0, status[15], wake_req}, 32'h3);
        step();
        chk("R4", "wake pulse ends", {31'h0, wake_req}, 32'h0);
        idle();

        for (int i = 0; i < 4000; i++) begin
            randomize_inputs();
            step();
        end
        idle(); step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule